// File: doc/BRIEF.md
# Operand Forwarding and Interlock Unit

This block is the hazard-control logic for an in-order integer pipeline with fetch, decode, execute, memory and write-back stages. It is purely combinational. From the register numbers named by the instructions in decode and execute, and from the destination, write-enable, load and store flags held in the three pipeline registers that follow decode, it produces three things. The first is a mux select for each of the two ALU operands. The second is a late store-data select used in the memory stage. The third is a single stall line.

The pipeline uses `stall` to hold the program counter and the fetch/decode register and to load a no-op with write-enable cleared into the decode/execute register. An ALU operand can come from the register file, from the execute/memory result or from the memory/write-back result. The newer value always wins. A producer three instructions ahead needs no path, because the register file writes in the first half of a cycle and reads in the second half. A load followed at once by a consumer costs one bubble.

A store whose data register is the only dependence on an immediately preceding load does not stall. Its data is replaced in the memory stage with the value from memory/write-back.

Top module: `fwd_hazard_unit`

## Requirements
- R1: When `exmem_we` is 1, `exmem_rd` is nonzero and equals an execute-stage source (`ex_rs1` for operand A, `ex_rs2` for operand B), that operand's select is 2'b10 (take the execute/memory result).
- R2: When R1 does not apply to an operand, `memwb_we` is 1, and `memwb_rd` is nonzero and equals that source, the select is 2'b01 (take the memory/write-back result).
- R3: When both later stages write the same nonzero source register, the select is 2'b10: the younger producer wins.
- R4: With no qualifying match, a select is 2'b00 (register file). This includes a producer that has already left memory/write-back. The code 2'b11 never appears.
- R5: Register 0 never produces a select other than 2'b00, never raises `stall`, and never raises `sd_late_fwd`.
- R6: `stall` is 1 when `idex_load` and `idex_we` are both 1, `idex_rd` is nonzero, and `idex_rd` equals `id_rs1` with `id_use_rs1` set, or equals `id_rs2` with `id_use_rs2` set and `id_is_store` clear.
- R7: `stall` is 0 when the decode-stage source is marked unused, when the execute-stage producer is not a load, or when its write-enable is clear.
- R8: For a store in decode (`id_is_store` = 1), a match on `id_rs2` alone (the data register) does not raise `stall`. A match on `id_rs1` (the base register) still does.
- R9: `sd_late_fwd` is 1 exactly when `exmem_is_store` is 1, `memwb_we` is 1, and `memwb_rd` is nonzero and equals `exmem_sd_reg`. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | Decode-stage first source register |
| id_rs2 | input | AW | Decode-stage second source register |
| id_use_rs1 | input | 1 | Decode instruction reads id_rs1 |
| id_use_rs2 | input | 1 | Decode instruction reads id_rs2 |
| id_is_store | input | 1 | Decode instruction is a store (id_rs2 is its data) |
| ex_rs1 | input | AW | Execute-stage source for ALU operand A |
| ex_rs2 | input | AW | Execute-stage source for ALU operand B / store data |
| idex_rd | input | AW | Destination held in decode/execute register |
| idex_we | input | 1 | Write-enable held in decode/execute register |
| idex_load | input | 1 | Decode/execute instruction is a load |
| exmem_rd | input | AW | Destination held in execute/memory register |
| exmem_we | input | 1 | Write-enable held in execute/memory register |
| exmem_is_store | input | 1 | Execute/memory instruction is a store |
| exmem_sd_reg | input | AW | Data register of the store in execute/memory |
| memwb_rd | input | AW | Destination held in memory/write-back register |
| memwb_we | input | 1 | Write-enable held in memory/write-back register |
| fwd_a_sel | output | 2 | Operand A select: 00 file, 10 exe/mem, 01 mem/wb |
| fwd_b_sel | output | 2 | Operand B select, same encoding |
| sd_late_fwd | output | 1 | Replace store data in memory stage with mem/wb value |
| stall | output | 1 | Hold PC and fetch/decode, bubble decode/execute |

AW is $clog2(REG_COUNT), which is 5 for the default of 32 registers.

## Verification
The bench builds the unit with the default 32-entry register space. Most random register numbers are drawn from the four lowest indices, so matches, double matches and register-0 cases occur often. The remaining draws cover the full 5-bit range and exercise the wide compare. Directed vectors pin the priority, register-0, load-use, store-data exemption and late store-data cases before the random phase begins.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Operand source select; the bit positions are decoded by the operand muxes.
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMWB   = 2'b01,
    SRC_EXMEM   = 2'b10
  } src_sel_e;
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel #(
  parameter int AW = 5
) (
  input  logic [AW-1:0]      src,
  input  logic [AW-1:0]      near_rd,
  input  logic               near_we,
  input  logic [AW-1:0]      far_rd,
  input  logic               far_we,
  output fwd_pkg::src_sel_e  sel
);
  import fwd_pkg::*;

  function automatic logic producer_hits(input logic [AW-1:0] rd,
                                         input logic we,
                                         input logic [AW-1:0] rs);
    return we && (rd != '0) && (rd == rs);
  endfunction

  logic near_hit;
  logic far_hit;

  assign near_hit = producer_hits(near_rd, near_we, src);
  assign far_hit  = producer_hits(far_rd, far_we, src);

  always_comb begin
    if (near_hit)     sel = SRC_EXMEM;
    else if (far_hit) sel = SRC_MEMWB;
    else              sel = SRC_REGFILE;
  end

  always_comb begin
    AST_SRC0_FROM_FILE: assert (src != '0 || sel == SRC_REGFILE) else $error("reg0 forwarded"); // R5
    AST_FAR_ONLY_WHEN_NEAR_MISS: assert (!(sel == SRC_MEMWB && near_we && near_rd == src)) else $error("older value chosen"); // R3
  end
endmodule

// File: rtl/fwd_load_use.sv
module fwd_load_use #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic          id_is_store,
  input  logic [AW-1:0] idex_rd,
  input  logic          idex_we,
  input  logic          idex_load,
  output logic          stall
);
  logic load_pending;
  logic base_dep;
  logic data_dep;

  assign load_pending = idex_load && idex_we && (idex_rd != '0);
  assign base_dep     = id_use_rs1 && (id_rs1 == idex_rd);
  // A store's data register is served later in the memory stage.
  assign data_dep     = id_use_rs2 && !id_is_store && (id_rs2 == idex_rd);
  assign stall        = load_pending && (base_dep || data_dep);
endmodule

// File: rtl/fwd_store_late.sv
module fwd_store_late #(
  parameter int AW = 5
) (
  input  logic          exmem_is_store,
  input  logic [AW-1:0] exmem_sd_reg,
  input  logic [AW-1:0] memwb_rd,
  input  logic          memwb_we,
  output logic          sd_late_fwd
);
  logic reg_match;

  assign reg_match   = (memwb_rd == exmem_sd_reg) && (memwb_rd != '0);
  assign sd_late_fwd = exmem_is_store && memwb_we && reg_match;
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int REG_COUNT = 32,
  localparam int AW = $clog2(REG_COUNT)
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic          id_is_store,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] idex_rd,
  input  logic          idex_we,
  input  logic          idex_load,
  input  logic [AW-1:0] exmem_rd,
  input  logic          exmem_we,
  input  logic          exmem_is_store,
  input  logic [AW-1:0] exmem_sd_reg,
  input  logic [AW-1:0] memwb_rd,
  input  logic          memwb_we,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic          sd_late_fwd,
  output logic          stall
);
  import fwd_pkg::*;

  localparam int NUM_OPS = 2;

  logic [AW-1:0] op_src [NUM_OPS];
  src_sel_e      op_sel [NUM_OPS];

  assign op_src[0] = ex_rs1;
  assign op_src[1] = ex_rs2;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_operand_sel #(.AW(AW)) u_sel (
      .src     (op_src[g]),
      .near_rd (exmem_rd),
      .near_we (exmem_we),
      .far_rd  (memwb_rd),
      .far_we  (memwb_we),
      .sel     (op_sel[g])
    );
  end

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];

  fwd_load_use #(.AW(AW)) u_load_use (
    .id_rs1      (id_rs1),
    .id_rs2      (id_rs2),
    .id_use_rs1  (id_use_rs1),
    .id_use_rs2  (id_use_rs2),
    .id_is_store (id_is_store),
    .idex_rd     (idex_rd),
    .idex_we     (idex_we),
    .idex_load   (idex_load),
    .stall       (stall)
  );

  fwd_store_late #(.AW(AW)) u_store_late (
    .exmem_is_store (exmem_is_store),
    .exmem_sd_reg   (exmem_sd_reg),
    .memwb_rd       (memwb_rd),
    .memwb_we       (memwb_we),
    .sd_late_fwd    (sd_late_fwd)
  );

  always_comb begin
    AST_A_LEGAL_CODE: assert (fwd_a_sel != 2'b11) else $error("bad A code"); // R4
    AST_B_LEGAL_CODE: assert (fwd_b_sel != 2'b11) else $error("bad B code"); // R4
    AST_STALL_NEEDS_LOAD: assert (!stall || (idex_load && idex_we)) else $error("stall without load"); // R6
    AST_NO_STALL_ON_R0: assert (!stall || idex_rd != '0) else $error("stall on reg0"); // R5
    AST_LATE_NEEDS_STORE: assert (!sd_late_fwd || (exmem_is_store && memwb_we)) else $error("late fwd w/o store"); // R9
    AST_EXMEM_SEL_NEEDS_WE: assert (fwd_a_sel != 2'b10 || exmem_we) else $error("A from idle stage"); // R1
  end
endmodule

// File: tb/fwd_hazard_unit_tb.sv
module fwd_hazard_unit_tb;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, idex_rd, exmem_rd, exmem_sd_reg, memwb_rd;
  logic id_use_rs1, id_use_rs2, id_is_store, idex_we, idex_load;
  logic exmem_we, exmem_is_store, memwb_we;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic sd_late_fwd, stall;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  fwd_hazard_unit u_dut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .id_is_store(id_is_store), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .idex_rd(idex_rd), .idex_we(idex_we), .idex_load(idex_load),
    .exmem_rd(exmem_rd), .exmem_we(exmem_we), .exmem_is_store(exmem_is_store),
    .exmem_sd_reg(exmem_sd_reg), .memwb_rd(memwb_rd), .memwb_we(memwb_we),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .sd_late_fwd(sd_late_fwd), .stall(stall)
  );

  // Reference model, written from the requirements with integers.
  function automatic int ref_sel(int src);
    int r1 = int'(exmem_rd), r2 = int'(memwb_rd);
    if (src == 0) return 0;
    if (exmem_we && r1 == src) return 2;   // code 10
    if (memwb_we && r2 == src) return 1;   // code 01
    return 0;
  endfunction

  function automatic int ref_stall();
    int d = int'(idex_rd);
    bit hit;
    if (!(idex_load && idex_we) || d == 0) return 0;
    hit = (id_use_rs1 && int'(id_rs1) == d) ||
          (id_use_rs2 && !id_is_store && int'(id_rs2) == d);
    return hit ? 1 : 0;
  endfunction

  function automatic int ref_late();
    if (exmem_is_store && memwb_we && memwb_rd != 0 && memwb_rd == exmem_sd_reg) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(int e);
    return (e == 2) ? "R1" : (e == 1) ? "R2" : "R4";
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Compare all outputs away from the clock edge; empty tag = derive it.
  task automatic check(string tag);
    int ea, eb, es, el;
    @(negedge clk);
    vectors++;
    ea = ref_sel(int'(ex_rs1));
    eb = ref_sel(int'(ex_rs2));
    es = ref_stall();
    el = ref_late();
    cmp(tag != "" ? tag : sel_tag(ea), "fwd_a_sel", int'(fwd_a_sel), ea);
    cmp(tag != "" ? tag : sel_tag(eb), "fwd_b_sel", int'(fwd_b_sel), eb);
    cmp(tag != "" ? tag : "R6", "stall", int'(stall), es);
    cmp(tag != "" ? tag : "R9", "sd_late_fwd", int'(sd_late_fwd), el);
  endtask

  task automatic idle();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, idex_rd, exmem_rd, exmem_sd_reg, memwb_rd} = '0;
    {id_use_rs1, id_use_rs2, id_is_store, idex_we, idex_load} = '0;
    {exmem_we, exmem_is_store, memwb_we} = '0;
  endtask

  function automatic logic [AW-1:0] pick_reg();
    if ($urandom % 4 == 0) return AW'($urandom % 32);
    return AW'($urandom % 4);
  endfunction

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle();
    check("R4");                                   // idle inputs: all zero outputs
    // R1: younger producer matches operand A
    exmem_rd = 5; exmem_we = 1; ex_rs1 = 5; check("R1");
    // R2: older producer matches operand B
    idle(); memwb_rd = 6; memwb_we = 1; ex_rs2 = 6; check("R2");
    // R3: both producers write the same source
    exmem_rd = 6; exmem_we = 1; ex_rs1 = 6; check("R3");
    // R4: no match, and a cleared write-enable does not count
    idle(); exmem_rd = 8; memwb_rd = 8; ex_rs1 = 9; ex_rs2 = 10; exmem_we = 1; memwb_we = 1; check("R4");
    exmem_we = 0; memwb_we = 0; ex_rs1 = 8; check("R4");
    // R5: register 0 everywhere
    idle(); exmem_we = 1; memwb_we = 1; idex_we = 1; idex_load = 1;
    id_use_rs1 = 1; id_use_rs2 = 1; exmem_is_store = 1; check("R5");
    // R6: load-use on each source
    idle(); idex_rd = 3; idex_we = 1; idex_load = 1; id_rs1 = 3; id_use_rs1 = 1; check("R6");
    id_rs1 = 2; id_rs2 = 3; id_use_rs2 = 1; check("R6");
    // R7: no stall without use, without load, or without write
    id_use_rs2 = 0; check("R7");
    id_use_rs2 = 1; idex_load = 0; check("R7");
    idex_load = 1; idex_we = 0; check("R7");
    // R8: store data register exempt, base register not
    idex_we = 1; id_is_store = 1; check("R8");
    id_rs1 = 3; check("R8");
    // R9: late store-data replacement
    idle(); exmem_is_store = 1; exmem_sd_reg = 4; memwb_rd = 4; memwb_we = 1; check("R9");
    exmem_is_store = 0; check("R9");
    exmem_is_store = 1; memwb_we = 0; check("R9");
    memwb_we = 1; exmem_sd_reg = 0; memwb_rd = 0; check("R9");

    for (int i = 0; i < 3000; i++) begin
      id_rs1 = pick_reg(); id_rs2 = pick_reg(); ex_rs1 = pick_reg(); ex_rs2 = pick_reg();
      idex_rd = pick_reg(); exmem_rd = pick_reg(); exmem_sd_reg = pick_reg(); memwb_rd = pick_reg();
      id_use_rs1 = 1'($urandom); id_use_rs2 = 1'($urandom); id_is_store = 1'($urandom);
      idex_we = 1'($urandom); idex_load = 1'($urandom); exmem_we = 1'($urandom);
      exmem_is_store = 1'($urandom); memwb_we = 1'($urandom);
      check("");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule